// File: doc/BRIEF.md
# Timestamped Event History Buffer

The block keeps a wall-clock time base and logs timestamped events into a circular on-chip memory that a host reads back later. The time base has two parts. The first is a 32-bit seconds count that the host can load directly. The second is a microseconds counter that advances once per microsecond, where a microsecond is a parameterised number of clock cycles. A pulse-per-second input, synchronised inside the block, realigns the microseconds counter to zero on each of its rising edges.

Each cycle in which the event strobe is high, the block stores one record. The record holds the current seconds and microseconds values together with the event's status, visibility, kind, sub-kind and detail fields. A record is presented to the host as four 32-bit words.

Readout has two steps. A start-read pulse freezes a snapshot of the buffer contents. Each read request after that returns the next 32-bit word, one cycle later. Records come out oldest first, four words per record. Event logging continues while a readout is in progress.

Top module: `ehb_top`

## Requirements
- R1: While reset is high and right after it is released, cur_sec and cur_usec are 0, overflow is 0, rd_empty is 1 and rd_valid is 0.
- R2: cur_usec advances by one every CYC_PER_US clock cycles. After US_PER_SEC-1 it returns to 0, and it never reaches US_PER_SEC.
- R3: When cur_usec wraps from US_PER_SEC-1 to 0, cur_sec increments by one on the same clock edge.
- R4: A cycle with sec_wr_en high loads sec_wr_data into cur_sec on that clock edge. The load takes priority over any increment in the same cycle.
- R5: pps_in passes through two synchronising flip-flops. On the third rising clock edge after pps_in rises, cur_usec becomes 0 and cur_sec increments by one. Keeping pps_in high has no further effect.
- R6: If the synchronised pps edge arrives in the cycle right after a microseconds wrap, cur_usec is cleared but cur_sec is not incremented a second time.
- R7: Every record reads back as four words, in index order 0 to 3:
  - word 0 is the seconds stamp;
  - word 1 is {usec stamp[19:0], status[11:0]};
  - word 2 is {vis[15:0], kind[1:0], sub[5:0], detail[7:0]};
  - word 3 is all zero.
- R8: An event strobed in the same cycle as a seconds write is stamped with the seconds value from before the write.
- R9: A pulse on rd_start captures the number of stored records. Each later rd_req cycle returns the next word on rd_data with rd_valid high one cycle later. Words come oldest record first and in word order 0 to 3 within each record.
- R10: Events logged during a readout do not change how many words that readout returns. rd_empty rises once the last word of the snapshot has been fetched.
- R11: The buffer holds 2^REC_AW records. Writing to a full buffer overwrites the oldest record and sets overflow. rd_start clears overflow.
- R12: An rd_req while rd_empty is high returns no word: rd_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| sec_wr_en | input | 1 | Load strobe for the seconds count |
| sec_wr_data | input | 32 | Seconds value to load |
| evt_valid | input | 1 | Event strobe; one record per cycle high |
| evt_status | input | 12 | Event status field |
| evt_vis | input | 16 | Event visibility field |
| evt_kind | input | 2 | Event kind field |
| evt_sub | input | 6 | Event sub-kind field |
| evt_detail | input | 8 | Event detail field |
| rd_start | input | 1 | Freeze a readout snapshot |
| rd_req | input | 1 | Fetch the next readout word |
| rd_data | output | 32 | Readout word |
| rd_valid | output | 1 | rd_data holds a fetched word |
| rd_empty | output | 1 | No words left in the current snapshot |
| overflow | output | 1 | A record was overwritten since the last rd_start |
| cur_sec | output | 32 | Current seconds count |
| cur_usec | output | 20 | Current microseconds count |

## Verification
A prescaler or microsecond counter that drifts shows up on cur_usec within one microsecond. A wrong carry into seconds shows up at the next wrap. Both are caught by a long sweep of consecutive cycles compared against modular arithmetic. A fault in the pps synchroniser or in the wrap-suppression rule moves the clearing edge, or adds an extra seconds increment, within three or four cycles of the pulse.

Pointer or count faults in the ring only show up on the readout path. They appear as a wrong record order, a word returned from the wrong slot, or a wrong word count before rd_empty. Full-buffer wrap-around and a readout overlapped with new writes are therefore read back word by word.

// File: rtl/ehb_pkg.sv
package ehb_pkg;

    localparam int USEC_W = 20;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [31:0]       sec;
        logic [USEC_W-1:0] usec;
        logic [11:0]       status;
        logic [15:0]       vis;
        logic [1:0]        kind;
        logic [5:0]        sub;
        logic [7:0]        detail;
    } ehb_rec_t;

    // Select one 32-bit host word out of a stored record.
    function automatic logic [WORD_W-1:0] ehb_word(ehb_rec_t r, logic [1:0] idx);
        case (idx)
            2'd0:    return r.sec;
            2'd1:    return {r.usec, r.status};
            2'd2:    return {r.vis, r.kind, r.sub, r.detail};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ehb_timebase.sv
module ehb_timebase
    import ehb_pkg::*;
#(
    parameter int US_PER_SEC = 1000000,
    parameter int CYC_PER_US = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_in,
    input  logic              sec_wr_en,
    input  logic [31:0]       sec_wr_data,
    output logic [31:0]       sec_o,
    output logic [USEC_W-1:0] usec_o,
    output logic              pps_edge_o
);

    localparam int                PW        = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PW-1:0]     PRE_LAST  = PW'(CYC_PER_US - 1);
    localparam logic [USEC_W-1:0] USEC_LAST = USEC_W'(US_PER_SEC - 1);

    logic [2:0]    sync_q;      // [0],[1] synchroniser, [2] edge history
    logic [PW-1:0] pre_q;
    logic          wrapped_q;   // a wrap happened on the previous edge
    logic          tick, at_top, wrap_now, bump;

    always_comb begin
        pps_edge_o = sync_q[1] & ~sync_q[2];
        tick       = (pre_q == PRE_LAST);
        at_top     = (usec_o == USEC_LAST);
        wrap_now   = !pps_edge_o && tick && at_top;
        bump       = wrap_now || (pps_edge_o && !wrapped_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            pre_q     <= '0;
            usec_o    <= '0;
            sec_o     <= '0;
            wrapped_q <= 1'b0;
        end else begin
            sync_q    <= {sync_q[1:0], pps_in};
            wrapped_q <= wrap_now;
            if (pps_edge_o || tick) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
            if (pps_edge_o)  usec_o <= '0;
            else if (tick)   usec_o <= at_top ? '0 : usec_o + 1'b1;
            if (sec_wr_en)   sec_o <= sec_wr_data;
            else if (bump)   sec_o <= sec_o + 32'd1;
        end
    end

endmodule

// File: rtl/ehb_ring.sv
module ehb_ring
    import ehb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  ehb_rec_t          wr_rec,
    input  logic              rd_start,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty,
    output logic              overflow,
    output logic [AW:0]       count_o
);

    localparam int            DEPTH   = 1 << AW;
    localparam logic [AW:0]   FULL_CT = (AW+1)'(DEPTH);

    ehb_rec_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   left_q;
    logic [1:0]    widx_q;
    logic          full;

    assign full     = (count_o == FULL_CT);
    assign rd_empty = (left_q == '0);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            count_o  <= '0;
            rd_ptr   <= '0;
            left_q   <= '0;
            widx_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            overflow <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (!full) count_o <= count_o + 1'b1;
            end
            if (wr_en && full) overflow <= 1'b1;
            else if (rd_start) overflow <= 1'b0;

            if (rd_start) begin
                rd_ptr <= wr_ptr - count_o[AW-1:0];
                left_q <= count_o;
                widx_q <= '0;
            end else if (rd_req && !rd_empty) begin
                rd_data  <= ehb_word(mem[rd_ptr], widx_q);
                rd_valid <= 1'b1;
                widx_q   <= widx_q + 1'b1;
                if (widx_q == 2'd3) begin
                    rd_ptr <= rd_ptr + 1'b1;
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ehb_top.sv
module ehb_top
    import ehb_pkg::*;
#(
    parameter int REC_AW     = 10,
    parameter int US_PER_SEC = 1000000,
    parameter int CYC_PER_US = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pps_in,
    input  logic        sec_wr_en,
    input  logic [31:0] sec_wr_data,
    input  logic        evt_valid,
    input  logic [11:0] evt_status,
    input  logic [15:0] evt_vis,
    input  logic [1:0]  evt_kind,
    input  logic [5:0]  evt_sub,
    input  logic [7:0]  evt_detail,
    input  logic        rd_start,
    input  logic        rd_req,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        rd_empty,
    output logic        overflow,
    output logic [31:0] cur_sec,
    output logic [19:0] cur_usec
);

    ehb_rec_t      stamp;
    logic          pps_edge_w;
    logic [REC_AW:0] rec_count_w;

    ehb_timebase #(
        .US_PER_SEC(US_PER_SEC),
        .CYC_PER_US(CYC_PER_US)
    ) u_time (
        .clk        (clk),
        .rst        (rst),
        .pps_in     (pps_in),
        .sec_wr_en  (sec_wr_en),
        .sec_wr_data(sec_wr_data),
        .sec_o      (cur_sec),
        .usec_o     (cur_usec),
        .pps_edge_o (pps_edge_w)
    );

    // Stamp uses the registered time, so a same-cycle seconds load is not seen.
    always_comb begin
        stamp.sec    = cur_sec;
        stamp.usec   = cur_usec;
        stamp.status = evt_status;
        stamp.vis    = evt_vis;
        stamp.kind   = evt_kind;
        stamp.sub    = evt_sub;
        stamp.detail = evt_detail;
    end

    ehb_ring #(
        .AW(REC_AW)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (evt_valid),
        .wr_rec  (stamp),
        .rd_start(rd_start),
        .rd_req  (rd_req),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .rd_empty(rd_empty),
        .overflow(overflow),
        .count_o (rec_count_w)
    );

endmodule

// File: rtl/ehb_chk.sv
module ehb_chk #(
    parameter int US_PER_SEC = 1000000,
    parameter int AW         = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        pps_edge,
    input logic [31:0] cur_sec,
    input logic [19:0] cur_usec,
    input logic        sec_wr_en,
    input logic [31:0] sec_wr_data,
    input logic        evt_valid,
    input logic        rd_start,
    input logic        rd_req,
    input logic        rd_valid,
    input logic        rd_empty,
    input logic        overflow,
    input logic [AW:0] count
);

    // R2
    usec_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cur_usec) < US_PER_SEC);

    // R4
    sec_load_chk: assert property (@(posedge clk) disable iff (rst)
        sec_wr_en |=> cur_sec == $past(sec_wr_data));

    // R5
    pps_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pps_edge |=> cur_usec == 20'd0);

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= (1 << AW));

    // R11
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(evt_valid));

    // R12
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_empty && rd_req && !rd_start) |=> !rd_valid);

    // R9
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

endmodule

bind ehb_top ehb_chk #(
    .US_PER_SEC(US_PER_SEC),
    .AW        (REC_AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pps_edge   (pps_edge_w),
    .cur_sec    (cur_sec),
    .cur_usec   (cur_usec),
    .sec_wr_en  (sec_wr_en),
    .sec_wr_data(sec_wr_data),
    .evt_valid  (evt_valid),
    .rd_start   (rd_start),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_empty   (rd_empty),
    .overflow   (overflow),
    .count      (rec_count_w)
);

// File: tb/tb_ehb_top.sv
module tb_ehb_top;

    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int USP   = 50;

    logic        clk = 1'b0;
    logic        rst, pps_in, sec_wr_en, evt_valid, rd_start, rd_req;
    logic [31:0] sec_wr_data;
    logic [11:0] evt_status;
    logic [15:0] evt_vis;
    logic [1:0]  evt_kind;
    logic [5:0]  evt_sub;
    logic [7:0]  evt_detail;
    logic [31:0] rd_data, cur_sec;
    logic [19:0] cur_usec;
    logic        rd_valid, rd_empty, overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_w [0:15][0:3];

    always #2 clk = ~clk;

    ehb_top #(.REC_AW(AW), .US_PER_SEC(USP), .CYC_PER_US(1)) dut (
        .clk(clk), .rst(rst), .pps_in(pps_in),
        .sec_wr_en(sec_wr_en), .sec_wr_data(sec_wr_data),
        .evt_valid(evt_valid), .evt_status(evt_status), .evt_vis(evt_vis),
        .evt_kind(evt_kind), .evt_sub(evt_sub), .evt_detail(evt_detail),
        .rd_start(rd_start), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_empty(rd_empty), .overflow(overflow),
        .cur_sec(cur_sec), .cur_usec(cur_usec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_usec(input int v);
        while (32'(cur_usec) != v) @(negedge clk);
    endtask

    // Called right after a negedge; stamps are the values the capturing edge sees.
    task automatic send_evt(input int i, input bit swr, input logic [31:0] sv);
        logic [11:0] st;
        logic [15:0] vi;
        logic [1:0]  ki;
        logic [5:0]  su;
        logic [7:0]  de;
        st = 12'(i * 37 + 5);
        vi = 16'(i * 4099 + 1);
        ki = 2'(i);
        su = 6'(i * 3 + 1);
        de = 8'(i * 11 + 2);
        exp_w[i][0] = cur_sec;
        exp_w[i][1] = {cur_usec, st};
        exp_w[i][2] = {vi, ki, su, de};
        exp_w[i][3] = 32'd0;
        evt_status = st; evt_vis = vi; evt_kind = ki; evt_sub = su; evt_detail = de;
        evt_valid = 1'b1;
        sec_wr_en = swr;
        sec_wr_data = sv;
        @(negedge clk);
        evt_valid = 1'b0;
        sec_wr_en = 1'b0;
    endtask

    task automatic start_read();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic read_word(output logic v, output logic [31:0] d);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    initial begin
        #(200000 * 4);
        $display("FAIL watchdog: actual timeout expected completion");
        n_bad++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] s0, u0, s;
        logic        v;
        logic [31:0] d;
        pps_in = 0; sec_wr_en = 0; sec_wr_data = 0; evt_valid = 0;
        evt_status = 0; evt_vis = 0; evt_kind = 0; evt_sub = 0; evt_detail = 0;
        rd_start = 0; rd_req = 0;
        do_reset();

        // R1 reset state
        chk("R1 sec", cur_sec, 0);
        chk("R1 usec", 32'(cur_usec), 0);
        chk("R1 overflow", 32'(overflow), 0);
        chk("R1 rd_empty", 32'(rd_empty), 1);
        chk("R1 rd_valid", 32'(rd_valid), 0);

        // R2 / R3 free-running sweep across several wraps
        s0 = cur_sec; u0 = 32'(cur_usec);
        for (int n = 1; n <= 130; n++) begin
            @(negedge clk);
            chk("R2 usec sweep", 32'(cur_usec), (u0 + n) % USP);
            chk("R3 sec carry", cur_sec, s0 + (u0 + n) / USP);
        end

        // R4 plain load, then load on a wrap edge
        sec_wr_en = 1'b1; sec_wr_data = 32'h1234_0000;
        @(negedge clk);
        sec_wr_en = 1'b0;
        chk("R4 load", cur_sec, 32'h1234_0000);
        wait_usec(USP - 1);
        sec_wr_en = 1'b1; sec_wr_data = 32'hA000_0005;
        @(negedge clk);
        sec_wr_en = 1'b0;
        chk("R4 load beats carry", cur_sec, 32'hA000_0005);
        chk("R2 wrap under load", 32'(cur_usec), 0);

        // R5 pps mid-second
        wait_usec(10);
        pps_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        s = cur_sec;
        @(negedge clk);
        chk("R5 pps clears usec", 32'(cur_usec), 0);
        chk("R5 pps bumps sec", cur_sec, s + 1);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R5 held pps no effect", 32'(cur_usec), k);
        end
        chk("R5 sec after hold", cur_sec, s + 1);
        pps_in = 1'b0;
        repeat (4) @(negedge clk);

        // R6 pps edge one cycle after a wrap
        wait_usec(USP - 2);
        s = cur_sec;
        pps_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 wrap before pps", cur_sec, s + 1);
        chk("R3 usec wrapped", 32'(cur_usec), 0);
        @(negedge clk);
        chk("R6 usec cleared", 32'(cur_usec), 0);
        chk("R6 no double bump", cur_sec, s + 1);
        @(negedge clk);
        chk("R6 usec resumes", 32'(cur_usec), 1);
        pps_in = 1'b0;
        repeat (4) @(negedge clk);

        // Readout with a write overlapping it
        do_reset();
        for (int i = 0; i < 5; i++) begin
            send_evt(i, i == 2, 32'h0000_BEEF);
            @(negedge clk);
        end
        chk("R8 load took effect", cur_sec, 32'h0000_BEEF);
        chk("R8 old sec stamped", exp_w[2][0], exp_w[1][0]);
        start_read();
        chk("R9 snapshot not empty", 32'(rd_empty), 0);
        for (int r = 0; r < 5; r++) begin
            for (int w = 0; w < 4; w++) begin
                if (r == 1 && w == 2) send_evt(5, 1'b0, 32'd0);
                read_word(v, d);
                chk("R9 word valid", 32'(v), 1);
                chk((w == 3) ? "R7 word3 zero" : "R7 R9 word data", d, exp_w[r][w]);
            end
        end
        chk("R10 empty after snapshot", 32'(rd_empty), 1);
        read_word(v, d);
        chk("R12 no word when empty", 32'(v), 0);

        // R11 overwrite when full
        do_reset();
        for (int i = 0; i < 11; i++) begin
            send_evt(i, 1'b0, 32'd0);
            if (i == DEPTH - 1) chk("R11 no overflow at full", 32'(overflow), 0);
            if (i == DEPTH)     chk("R11 overflow set", 32'(overflow), 1);
        end
        start_read();
        chk("R11 overflow cleared", 32'(overflow), 0);
        for (int r = 0; r < DEPTH; r++) begin
            for (int w = 0; w < 4; w++) begin
                read_word(v, d);
                chk("R11 oldest-first after wrap", d, exp_w[r + 3][w]);
            end
        end
        chk("R10 empty after full read", 32'(rd_empty), 1);
        start_read();
        read_word(v, d);
        chk("R9 re-read oldest", d, exp_w[3][0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule